// File: doc/BRIEF.md
# Multichannel ADC scan sequencer

This block is the host-side controller for a pipelined eight-channel analog-to-digital converter whose input multiplexer is selected by a three-bit address and an active-low write strobe. On a start pulse it latches an eight-bit channel enable mask, a mode bit and a strobe length. It then visits the enabled channels in ascending order. For each visit it sets the address up one cycle ahead of the strobe and holds the strobe low for the programmed number of clocks. It keeps the address steady until the strobe has returned high.

The converter samples on every rising clock edge, and each result appears 1.5 clocks after its sample edge. The sample that straddles a channel switch is corrupt. The sequencer therefore skips the sample that ends one cycle after the strobe rises and takes the next one. It carries that sample's channel tag through a delay line matched to the converter latency, and registers the returned ten-bit word and overflow flag together with the tag.

Single-scan mode stops after one pass. Continuous mode repeats until a stop request, and can rest the converter in power-down between passes. Power-down is never raised while a result is still on its way.

Top module: `adc_scan_seq`

## Requirements
- R1: Channel index i (channels 0 to 7, the converter's inputs 1 to 8) is driven on `conv_addr` as the 3-bit binary code i, and the result taken on that channel carries the same code on `res_chan`.
- R2: For each channel visit, `conv_wr_n` goes low for exactly `wr_len` consecutive cycles, and for one cycle when `wr_len` is 0. `conv_addr` holds its value in the cycle before the strobe falls, during the strobe, and in the cycle in which it rises.
- R3: The sample taken at the first rising edge after the strobe returns high is discarded. Exactly one result is produced per visit, from the sample at the second rising edge after the strobe rises.
- R4: `res_valid` is a one-cycle pulse. It rises at the fourth rising edge after the edge at which `conv_wr_n` returned high, two edges after the sample edge.
- R5: `res_data` and `res_ovf` are the converter's 10-bit word and overflow flag as presented at the capture edge of R4.
- R6: On start, the mask and mode are latched. Enabled channels are visited in ascending order, starting at the lowest enabled one. A single scan visits each enabled channel once.
- R7: In continuous mode, passes repeat with wrap-around from the highest enabled channel to the lowest. A `stop` pulse ends the run once the pass in progress has completed.
- R8: A start pulse with an all-zero mask is ignored: no strobe and no result follow.
- R9: `conv_pd` is high while idle with `nap_en` set, and never in a cycle in which a result is still in flight. In continuous mode with naps enabled, it is high between passes for exactly NAP_CYCLES − PIPE_STAGES cycles (4 with defaults).
- R10: `conv_pd` is low for at least WAKE_CYCLES + 1 cycles before any falling edge of `conv_wr_n`.
- R11: After reset, `conv_wr_n` is 1, `res_valid` is 0, `conv_addr` is 0, and `conv_pd` is 0 while `nap_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the converter sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run while idle |
| stop | input | 1 | Pulse that ends a continuous run at the end of the current pass |
| cont_mode | input | 1 | 1 = continuous scanning, 0 = single pass |
| nap_en | input | 1 | Enables power-down while idle and between passes |
| ch_mask | input | 8 | Channel enable mask, bit i enables channel i |
| wr_len | input | 4 | Strobe low time in clocks, 0 treated as 1 |
| conv_data | input | 10 | Converter result word |
| conv_ovf | input | 1 | Converter overflow flag |
| conv_addr | output | 3 | Multiplexer address to the converter |
| conv_wr_n | output | 1 | Active-low address write strobe |
| conv_pd | output | 1 | Converter power-down request |
| res_valid | output | 1 | Tagged result strobe |
| res_data | output | 10 | Result word |
| res_ovf | output | 1 | Result overflow flag |
| res_chan | output | 3 | Channel tag of the result |

## Verification
The entry into a between-pass nap and the delivery of the last result of the pass overlap. The final visit's tag is still in the delay line during the first two nap cycles. The bench provokes this by running continuous scans with naps enabled. Its converter model freezes whenever power-down is sampled high, so an early power-down would corrupt or duplicate the pending word. The scoreboard judges the result by its data and tag, and the bench also measures the length of the power-down run and the wake gap before the next strobe.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SETUP,
    ST_STROBE,
    ST_SETTLE,
    ST_TAKE,
    ST_NAP
  } scan_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int unsigned NCH         = 8,
  parameter int unsigned WLW         = 4,
  parameter int unsigned NAP_CYCLES  = 6,
  parameter int unsigned WAKE_CYCLES = 2,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic           cont_mode,
  input  logic           nap_en,
  input  logic [NCH-1:0] ch_mask,
  input  logic [WLW-1:0] wr_len,
  input  logic           in_flight,
  output logic [AW-1:0]  conv_addr,
  output logic           conv_wr_n,
  output logic           conv_pd,
  output logic           issue,
  output logic [AW-1:0]  issue_tag
);

  localparam int unsigned CW  = max2(max2($clog2(NAP_CYCLES + 1), $clog2(WAKE_CYCLES + 1)), WLW);
  localparam int unsigned PLW = $clog2(WAKE_CYCLES + 3);

  // next enabled channel above cur, wrapping; returns cur if no other is enabled
  function automatic logic [AW-1:0] pick_next(input logic [NCH-1:0] m, input logic [AW-1:0] cur);
    logic [AW-1:0] r;
    r = cur;
    for (int i = NCH - 1; i >= 1; i--) begin
      if (m[(int'(cur) + i) % NCH]) r = AW'((int'(cur) + i) % NCH);
    end
    return r;
  endfunction

  function automatic logic [WLW-1:0] strobe_len(input logic [WLW-1:0] l);
    return (l == '0) ? WLW'(1) : l;
  endfunction

  scan_state_t    state;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  chan, addr_q, nxt;
  logic [NCH-1:0] mask_q;
  logic [WLW-1:0] wrl_q;
  logic           cont_q, nap_q, stop_q, wrap;

  assign nxt  = pick_next(mask_q, chan);
  assign wrap = (nxt <= chan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      chan   <= '0;
      addr_q <= '0;
      mask_q <= '0;
      wrl_q  <= WLW'(1);
      cont_q <= 1'b0;
      nap_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (stop && state != ST_IDLE) stop_q <= 1'b1;
      case (state)
        ST_IDLE: if (start && |ch_mask) begin
          mask_q <= ch_mask;
          cont_q <= cont_mode;
          nap_q  <= nap_en;
          wrl_q  <= strobe_len(wr_len);
          stop_q <= 1'b0;
          chan   <= pick_next(ch_mask, AW'(NCH - 1));
          cnt    <= CW'(WAKE_CYCLES - 1);
          state  <= ST_WAKE;
        end
        ST_WAKE: if (cnt == '0) begin
          addr_q <= chan;
          state  <= ST_SETUP;
        end else cnt <= cnt - CW'(1);
        ST_SETUP: begin
          cnt   <= CW'(wrl_q) - CW'(1);
          state <= ST_STROBE;
        end
        ST_STROBE: if (cnt == '0) state <= ST_SETTLE;
                   else cnt <= cnt - CW'(1);
        ST_SETTLE: state <= ST_TAKE;
        ST_TAKE: begin
          chan <= nxt;
          if (!wrap) begin
            addr_q <= nxt;
            state  <= ST_SETUP;
          end else if (!cont_q || stop_q || stop) begin
            state <= ST_IDLE;
          end else if (nap_q) begin
            cnt   <= CW'(NAP_CYCLES - 1);
            state <= ST_NAP;
          end else begin
            addr_q <= nxt;
            state  <= ST_SETUP;
          end
        end
        ST_NAP: if (cnt == '0) begin
          cnt   <= CW'(WAKE_CYCLES - 1);
          state <= ST_WAKE;
        end else cnt <= cnt - CW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign conv_addr = addr_q;
  assign conv_wr_n = (state != ST_STROBE);
  assign conv_pd   = ((state == ST_IDLE && nap_en) || state == ST_NAP) && !in_flight;
  assign issue     = (state == ST_TAKE);
  assign issue_tag = chan;

  // observation counters for the assertions
  logic [WLW:0]   low_run;
  logic [PLW-1:0] pd_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      pd_low_run <= '0;
    end else begin
      low_run <= conv_wr_n ? '0 : low_run + (WLW+1)'(1);
      if (conv_pd) pd_low_run <= '0;
      else if (pd_low_run < PLW'(WAKE_CYCLES + 1)) pd_low_run <= pd_low_run + PLW'(1);
    end
  end

  p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_wr_n) |-> low_run == {1'b0, wrl_q});

  p_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_wr_n) |-> $stable(conv_addr));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_wr_n |=> $stable(conv_addr));

  p_wake_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_wr_n) |-> pd_low_run == PLW'(WAKE_CYCLES + 1));

  p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && ch_mask == '0) |=> state == ST_IDLE);

endmodule

// File: rtl/tag_pipe.sv
module tag_pipe #(
  parameter int unsigned AW          = 3,
  parameter int unsigned PIPE_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [AW-1:0] in_tag,
  output logic          out_v,
  output logic [AW-1:0] out_tag,
  output logic          in_flight
);

  logic [PIPE_STAGES-1:0] vq;
  logic [AW-1:0]          tq [PIPE_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0;
      for (int i = 0; i < PIPE_STAGES; i++) tq[i] <= '0;
    end else begin
      vq[0] <= in_v;
      tq[0] <= in_tag;
      for (int i = 1; i < PIPE_STAGES; i++) begin
        vq[i] <= vq[i-1];
        tq[i] <= tq[i-1];
      end
    end
  end

  assign out_v     = vq[PIPE_STAGES-1];
  assign out_tag   = tq[PIPE_STAGES-1];
  assign in_flight = |vq;

endmodule

// File: rtl/result_capture.sv
module result_capture #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_v,
  input  logic [AW-1:0] cap_tag,
  input  logic [DW-1:0] conv_data,
  input  logic          conv_ovf,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          res_ovf,
  output logic [AW-1:0] res_chan
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ovf   <= 1'b0;
      res_chan  <= '0;
    end else begin
      res_valid <= cap_v;
      if (cap_v) begin
        res_data <= conv_data;
        res_ovf  <= conv_ovf;
        res_chan <= cap_tag;
      end
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int unsigned NCH         = 8,
  parameter int unsigned DW          = 10,
  parameter int unsigned WLW         = 4,
  parameter int unsigned NAP_CYCLES  = 6,
  parameter int unsigned WAKE_CYCLES = 2,
  parameter int unsigned PIPE_STAGES = 2,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic           cont_mode,
  input  logic           nap_en,
  input  logic [NCH-1:0] ch_mask,
  input  logic [WLW-1:0] wr_len,
  input  logic [DW-1:0]  conv_data,
  input  logic           conv_ovf,
  output logic [AW-1:0]  conv_addr,
  output logic           conv_wr_n,
  output logic           conv_pd,
  output logic           res_valid,
  output logic [DW-1:0]  res_data,
  output logic           res_ovf,
  output logic [AW-1:0]  res_chan
);

  logic          issue, in_flight, cap_v;
  logic [AW-1:0] issue_tag, cap_tag;

  scan_fsm #(
    .NCH(NCH), .WLW(WLW), .NAP_CYCLES(NAP_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cont_mode(cont_mode), .nap_en(nap_en), .ch_mask(ch_mask), .wr_len(wr_len),
    .in_flight(in_flight), .conv_addr(conv_addr), .conv_wr_n(conv_wr_n),
    .conv_pd(conv_pd), .issue(issue), .issue_tag(issue_tag)
  );

  tag_pipe #(.AW(AW), .PIPE_STAGES(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(issue), .in_tag(issue_tag),
    .out_v(cap_v), .out_tag(cap_tag), .in_flight(in_flight)
  );

  result_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_v(cap_v), .cap_tag(cap_tag),
    .conv_data(conv_data), .conv_ovf(conv_ovf),
    .res_valid(res_valid), .res_data(res_data), .res_ovf(res_ovf), .res_chan(res_chan)
  );

  p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pd |=> !res_valid);

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

  localparam int NAP  = 6;
  localparam int WAKE = 2;
  localparam int PIPE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, cont_mode = 1'b0, nap_en = 1'b0;
  logic [7:0] ch_mask = '0;
  logic [3:0] wr_len = '0;
  logic [9:0] conv_data = '0;
  logic       conv_ovf = 1'b0;
  logic [2:0] conv_addr, res_chan;
  logic       conv_wr_n, conv_pd, res_valid, res_ovf;
  logic [9:0] res_data;

  int checks = 0, errors = 0;
  int got = 0, nfall = 0, exp_wrl = 1, ncyc = 0, rise_n = -100;
  int lowrun = 0, pd_hi = 0, pd_lo = 0, wd = 0;
  bit chk_nap = 0, done = 0;
  logic wr_prev = 1'b1, pd_prev = 1'b0;
  logic [2:0] addr_prev = '0;
  logic [13:0] q[$];

  logic [9:0] ana [8];
  logic [7:0] aovf;

  always #5 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cont_mode(cont_mode),
    .nap_en(nap_en), .ch_mask(ch_mask), .wr_len(wr_len), .conv_data(conv_data),
    .conv_ovf(conv_ovf), .conv_addr(conv_addr), .conv_wr_n(conv_wr_n),
    .conv_pd(conv_pd), .res_valid(res_valid), .res_data(res_data),
    .res_ovf(res_ovf), .res_chan(res_chan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: selection latched while strobe low, result 1.5 clocks after sample edge
  logic [2:0]  m_sel = '0;
  logic        m_wr_seen = 1'b0;
  logic [10:0] m_a = '0, m_b = '0;
  always @(posedge clk) begin
    if (!conv_pd) begin
      if (!conv_wr_n || m_wr_seen) m_a <= {~aovf[m_sel], ana[m_sel] ^ 10'h3C3};
      else                         m_a <= {aovf[m_sel], ana[m_sel]};
      m_b <= m_a;
      m_wr_seen <= !conv_wr_n;
      if (!conv_wr_n) m_sel <= conv_addr;
    end
  end
  always @(negedge clk) {conv_ovf, conv_data} <= m_b;

  // scoreboard monitor and protocol observer
  always @(negedge clk) begin
    if (rst_n) begin
      ncyc++;
      if (res_valid) begin
        chk(ncyc - rise_n == 4, "R4 latency", ncyc - rise_n, 4);
        if (q.size() == 0) chk(0, "R6 unexpected result chan", int'(res_chan), -1);
        else begin
          logic [13:0] e;
          e = q.pop_front();
          chk({res_chan, res_ovf, res_data} === e, "R1 R3 R5 R6 result", int'({res_chan, res_ovf, res_data}), int'(e));
          got++;
        end
      end
      if (!conv_wr_n && wr_prev) begin
        nfall++;
        chk(conv_addr == addr_prev, "R2 setup", int'(conv_addr), int'(addr_prev));
        chk(pd_lo >= WAKE + 1, "R10 wake gap", pd_lo, WAKE + 1);
        lowrun = 1;
      end else if (!conv_wr_n) begin
        chk(conv_addr == addr_prev, "R2 hold", int'(conv_addr), int'(addr_prev));
        lowrun++;
      end
      if (conv_wr_n && !wr_prev) begin
        chk(lowrun == exp_wrl, "R2 strobe width", lowrun, exp_wrl);
        chk(conv_addr == addr_prev, "R2 hold at rise", int'(conv_addr), int'(addr_prev));
        rise_n = ncyc;
      end
      if (conv_pd) begin
        pd_hi++;
        pd_lo = 0;
      end else begin
        if (pd_prev && chk_nap) chk(pd_hi == NAP - PIPE, "R9 nap length", pd_hi, NAP - PIPE);
        pd_hi = 0;
        pd_lo++;
      end
      wr_prev = conv_wr_n;
      addr_prev = conv_addr;
      pd_prev = conv_pd;
    end
  end

  task automatic push_pass(input logic [7:0] m);
    for (int i = 0; i < 8; i++)
      if (m[i]) q.push_back({3'(i), aovf[i], ana[i]});
  endtask

  task automatic kick(input logic [7:0] m, input bit cont, input bit nap, input logic [3:0] wl);
    @(negedge clk);
    ch_mask = m; cont_mode = cont; nap_en = nap; wr_len = wl;
    exp_wrl = (wl == 0) ? 1 : int'(wl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run;
    wait (q.size() == 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic pulse_stop;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int base, nf;
    for (int i = 0; i < 8; i++) ana[i] = 10'(i * 97 + 13);
    aovf = 8'b0100_0000;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(conv_wr_n == 1'b1, "R11 wr_n", int'(conv_wr_n), 1);
    chk(res_valid == 1'b0, "R11 valid", int'(res_valid), 0);
    chk(conv_addr == 3'd0, "R11 addr", int'(conv_addr), 0);
    chk(conv_pd == 1'b0, "R11 pd", int'(conv_pd), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: empty mask ignored
    nf = nfall;
    kick(8'h00, 1'b0, 1'b0, 4'd2);
    repeat (30) @(negedge clk);
    chk(nfall == nf, "R8 no strobe", nfall - nf, 0);
    chk(got == 0, "R8 no result", got, 0);

    // R6 single scan, sparse mask (channels 1,2,5,7), R5 overflow on channel 6 not visited
    push_pass(8'b1010_0110);
    kick(8'b1010_0110, 1'b0, 1'b0, 4'd3);
    finish_run();
    chk(got == 4, "R6 single pass count", got, 4);
    chk(conv_pd == 1'b0, "R9 no nap when disabled", int'(conv_pd), 0);

    // single channel 7 with overflow, strobe length 0 treated as 1 (R2, R5)
    aovf = 8'b1100_0000;
    base = got;
    push_pass(8'h80);
    kick(8'h80, 1'b0, 1'b0, 4'd0);
    finish_run();
    chk(got - base == 1, "R6 one channel", got - base, 1);

    // R7 continuous with naps, stop during pass 2; R9 nap length and idle power-down
    ana[0] = 10'h3FF;
    base = got;
    push_pass(8'h81);
    push_pass(8'h81);
    kick(8'h81, 1'b1, 1'b1, 4'd2);
    repeat (3) @(negedge clk);
    chk_nap = 1;
    wait (got == base + 3);
    pulse_stop();
    finish_run();
    chk_nap = 0;
    chk(got - base == 4, "R7 two passes then stop", got - base, 4);
    chk(conv_pd == 1'b1, "R9 idle power-down", int'(conv_pd), 1);

    // R7 continuous without naps, full mask, stop in first pass
    base = got;
    push_pass(8'hFF);
    kick(8'hFF, 1'b1, 1'b0, 4'd1);
    wait (got == base + 1);
    pulse_stop();
    finish_run();
    chk(got - base == 8, "R7 one full pass", got - base, 8);
    chk(q.size() == 0, "R6 queue drained", q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule